// File: doc/BRIEF.md
# Wakeup and Reset Request Gatherer

This block sits beside the sequencing logic of a power controller and collects the events that end a low-power period or force a reset. Six wakeup sources each pass through their own enable bit. An enabled wakeup raises a single-cycle wakeup event for the sequencer and sets a sticky interrupt status bit. It also records, per source, which line caused it, provided that recording is switched on. While the sequencer signals that low-power entry is in progress, no wakeup is sampled, so entry goes ahead unchanged.

On the reset side, each peripheral reset request passes through its own enable. Main-power-glitch, escalation and software reset requests are never masked. All of them are registered into one request vector. A two-bit cause output tells the reset manager whether the current reset comes from a request or from low-power entry. Enables, write-one-to-clear strobes and status values are plain register-style ports. Any bus decoding stays outside the block.

Top module: `wake_reset_gather`

## Requirements
- R1: Wakeup bit i refers to the same source in `wake_req_i`, `wake_en_i`, `wake_clr_i` and `wake_info_o`. The order is: 0 system-reset request, 1 debug cable, 2 pin, 3 USB, 4 always-on timer, 5 sensor controller.
- R2: A wakeup line counts only when its enable bit is set. `wake_evt_o` is high in the cycle after at least one enabled line was high, and low otherwise.
- R3: A bit of `wake_info_o` is set in the cycle after its enabled line was high, and only if `capture_en_i` was high at that time. With capture off, no bit of `wake_info_o` sets.
- R4: An enabled wakeup sets `irq_status_o` in the following cycle. `irq_o` is high exactly when `irq_status_o` and `irq_en_i` are both high.
- R5: Bit k of `rst_req_o` (k below NPR) is high in the cycle after `prst_req_i[k]` and `prst_en_i[k]` were both high, and low otherwise.
- R6: `rst_req_o` bit NPR follows the main-power-glitch input, bit NPR+1 follows escalation, and bit NPR+2 follows the software request. Each follows one cycle later, with no enable.
- R7: `rst_cause_o` is 2'b10 in the cycle after any bit of the next request vector is set. Otherwise it is 2'b01 in the cycle after `lp_rst_i` is high. Otherwise it is 2'b00.
- R8: While `lp_entry_i` is high, wakeup lines are ignored. They do not affect `wake_evt_o`, `wake_info_o` or `irq_status_o`.
- R9: `wake_info_o` bits stay set until a one is written to the matching bit of `wake_clr_i`. If the same bit is set and cleared in one cycle, the set wins.
- R10: `irq_clr_i` clears `irq_status_o`, but a new enabled wakeup in the same cycle leaves it set.
- R11: While `rst_ni` is low, `wake_info_o`, `irq_status_o`, `irq_o`, `wake_evt_o`, `rst_req_o` and `rst_cause_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wake_req_i | input | NW | Wakeup request lines |
| wake_en_i | input | NW | Per-source wakeup enables |
| capture_en_i | input | 1 | Allows wakeup recording |
| wake_clr_i | input | NW | Write-one-to-clear for recorded wakeups |
| lp_entry_i | input | 1 | Low-power entry in progress, blocks wakeup sampling |
| irq_en_i | input | 1 | Interrupt enable |
| irq_clr_i | input | 1 | Write-one-to-clear for interrupt status |
| prst_req_i | input | NPR | Peripheral reset requests |
| prst_en_i | input | NPR | Per-request reset enables |
| glitch_i | input | 1 | Main power glitch reset request |
| esc_i | input | 1 | Escalation reset request |
| sw_rst_i | input | 1 | Software reset request |
| lp_rst_i | input | 1 | Reset due to low-power entry |
| wake_evt_o | output | 1 | Enabled wakeup seen in the previous cycle |
| wake_info_o | output | NW | Recorded wakeup sources |
| irq_status_o | output | 1 | Interrupt status |
| irq_o | output | 1 | Interrupt output |
| rst_req_o | output | NPR+3 | Reset request vector |
| rst_cause_o | output | 2 | Reset cause: 00 none, 01 low power, 10 request |

## Verification
Every registered result appears exactly one clock after the inputs that cause it. This applies to the wakeup event, recorded wakeups, interrupt status, the request vector and the cause. The exception is `irq_o`, which follows `irq_en_i` within the same cycle. The bench drives inputs just after a falling edge and updates its reference model on the rising edge from those settled inputs. It then compares every output at the next falling edge, so each comparison lands one edge after the stimulus. The comparison of `irq_o` uses the enable value present at that moment.

// File: rtl/wake_reset_gather.sv
module wake_reset_gather #(
  parameter int NW  = 6,
  parameter int NPR = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NW-1:0]  wake_req_i,
  input  logic [NW-1:0]  wake_en_i,
  input  logic           capture_en_i,
  input  logic [NW-1:0]  wake_clr_i,
  input  logic           lp_entry_i,
  input  logic           irq_en_i,
  input  logic           irq_clr_i,
  input  logic [NPR-1:0] prst_req_i,
  input  logic [NPR-1:0] prst_en_i,
  input  logic           glitch_i,
  input  logic           esc_i,
  input  logic           sw_rst_i,
  input  logic           lp_rst_i,
  output logic           wake_evt_o,
  output logic [NW-1:0]  wake_info_o,
  output logic           irq_status_o,
  output logic           irq_o,
  output logic [NPR+2:0] rst_req_o,
  output logic [1:0]     rst_cause_o
);

  localparam int RV = NPR + 3;
  localparam logic [1:0] CauseNone = 2'b00;
  localparam logic [1:0] CauseLp   = 2'b01;
  localparam logic [1:0] CauseReq  = 2'b10;

  logic [NW-1:0] wake_hit;
  logic          any_wake;
  logic [RV-1:0] req_nxt;

  assign wake_hit = lp_entry_i ? '0 : (wake_req_i & wake_en_i);
  assign any_wake = |wake_hit;
  assign req_nxt  = {sw_rst_i, esc_i, glitch_i, prst_req_i & prst_en_i};
  assign irq_o    = irq_status_o & irq_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wake_evt_o   <= 1'b0;
      wake_info_o  <= '0;
      irq_status_o <= 1'b0;
    end else begin
      wake_evt_o   <= any_wake;
      wake_info_o  <= (wake_info_o & ~wake_clr_i) | (capture_en_i ? wake_hit : '0);
      irq_status_o <= (irq_status_o & ~irq_clr_i) | any_wake;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_req_o   <= '0;
      rst_cause_o <= CauseNone;
    end else begin
      rst_req_o   <= req_nxt;
      rst_cause_o <= (|req_nxt) ? CauseReq : (lp_rst_i ? CauseLp : CauseNone);
    end
  end

  // R2
  disabled_wake_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wake_req_i & wake_en_i) == '0) |=> !wake_evt_o);

  // R3
  no_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture_en_i |=> ((wake_info_o & ~$past(wake_info_o)) == '0));

  // R4
  irq_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lp_entry_i && ((wake_req_i & wake_en_i) != '0)) |=> irq_status_o);

  // R6
  esc_unmasked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    esc_i |=> rst_req_o[NPR+1]);

  // R6
  glitch_unmasked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    glitch_i |=> rst_req_o[NPR]);

  // R7
  req_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (glitch_i || esc_i || sw_rst_i) |=> (rst_cause_o == CauseReq));

  // R8
  lp_blocks_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lp_entry_i |=> !wake_evt_o);

  // R9
  info_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_clr_i == '0) |=> ((wake_info_o & $past(wake_info_o)) == $past(wake_info_o)));

  // R11
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_zero_chk: assert (wake_info_o == '0 && !irq_status_o && !irq_o &&
                              !wake_evt_o && rst_req_o == '0 && rst_cause_o == CauseNone);
    end
  end

endmodule

// File: tb/test_wake_reset_gather.sv
module test_wake_reset_gather;
  localparam int CLK_PERIOD = 10;
  localparam int NW  = 6;
  localparam int NPR = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NW-1:0] wake_req = '0, wake_en = '0, wake_clr = '0;
  logic capture_en = 1'b0, lp_entry = 1'b0, irq_en = 1'b0, irq_clr = 1'b0;
  logic [NPR-1:0] prst_req = '0, prst_en = '0;
  logic glitch = 1'b0, esc = 1'b0, sw_rst = 1'b0, lp_rst = 1'b0;

  logic wake_evt, irq_status, irq;
  logic [NW-1:0] wake_info;
  logic [NPR+2:0] rst_req;
  logic [1:0] rst_cause;

  int total = 0;
  int bad = 0;
  bit comparing = 1'b0;

  // reference state
  bit m_evt, m_stat;
  bit m_info [NW];
  bit m_req [NPR+3];
  int m_cause;

  always #(CLK_PERIOD/2) clk = ~clk;

  wake_reset_gather #(.NW(NW), .NPR(NPR)) i_wake_reset_gather (
    .clk_i(clk), .rst_ni(rst_n),
    .wake_req_i(wake_req), .wake_en_i(wake_en), .capture_en_i(capture_en),
    .wake_clr_i(wake_clr), .lp_entry_i(lp_entry), .irq_en_i(irq_en),
    .irq_clr_i(irq_clr), .prst_req_i(prst_req), .prst_en_i(prst_en),
    .glitch_i(glitch), .esc_i(esc), .sw_rst_i(sw_rst), .lp_rst_i(lp_rst),
    .wake_evt_o(wake_evt), .wake_info_o(wake_info), .irq_status_o(irq_status),
    .irq_o(irq), .rst_req_o(rst_req), .rst_cause_o(rst_cause)
  );

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_evt = 0; m_stat = 0; m_cause = 0;
      for (int i = 0; i < NW; i++) m_info[i] = 0;
      for (int i = 0; i < NPR+3; i++) m_req[i] = 0;
    end else begin
      bit hit_any;
      bit any_req;
      hit_any = 0;
      for (int i = 0; i < NW; i++) begin
        bit hit;
        hit = wake_req[i] && wake_en[i] && !lp_entry;
        if (hit) hit_any = 1;
        if (wake_clr[i]) m_info[i] = 0;
        if (hit && capture_en) m_info[i] = 1;
      end
      m_evt = hit_any;
      if (irq_clr) m_stat = 0;
      if (hit_any) m_stat = 1;
      any_req = 0;
      for (int k = 0; k < NPR; k++) m_req[k] = prst_req[k] && prst_en[k];
      m_req[NPR] = glitch;
      m_req[NPR+1] = esc;
      m_req[NPR+2] = sw_rst;
      for (int k = 0; k < NPR+3; k++) if (m_req[k]) any_req = 1;
      m_cause = any_req ? 2 : (lp_rst ? 1 : 0);
    end
  end

  function automatic longint pack_info();
    longint v = 0;
    for (int i = 0; i < NW; i++) if (m_info[i]) v |= (longint'(1) << i);
    return v;
  endfunction

  function automatic longint pack_req();
    longint v = 0;
    for (int k = 0; k < NPR+3; k++) if (m_req[k]) v |= (longint'(1) << k);
    return v;
  endfunction

  always @(negedge clk) begin
    if (comparing && rst_n) begin
      check("R2/R8 wake event", wake_evt, m_evt);
      check("R1/R3/R9 wake info", wake_info, pack_info());
      check("R4/R10 irq status", irq_status, m_stat);
      check("R4 irq output", irq, m_stat && irq_en);
      check("R5/R6 reset vector", rst_req, pack_req());
      check("R7 reset cause", rst_cause, m_cause);
    end
  end

  task automatic drive_idle();
    wake_req = '0; wake_clr = '0; irq_clr = 0; prst_req = '0;
    glitch = 0; esc = 0; sw_rst = 0; lp_rst = 0; lp_entry = 0;
  endtask

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic check_reset_zero();
    check("R11 info", wake_info, 0);
    check("R11 status", irq_status, 0);
    check("R11 irq", irq, 0);
    check("R11 event", wake_evt, 0);
    check("R11 req", rst_req, 0);
    check("R11 cause", rst_cause, 0);
  endtask

  task automatic run();
    irq_en = 1;
    repeat (3) tick();
    check_reset_zero();
    rst_n = 1;
    comparing = 1;
    tick();
    // R1: sensor controller is bit 5
    capture_en = 1; wake_en = 6'b100000; wake_req = 6'b100000;
    tick();
    drive_idle();
    check("R1 sensor bit", wake_info, 6'b100000);
    // R10: clear and set together keeps status
    irq_clr = 1; wake_req = 6'b100000;
    tick();
    drive_idle();
    check("R10 set wins", irq_status, 1);
    irq_clr = 1;
    tick();
    drive_idle();
    check("R10 clear", irq_status, 0);
    // R8: low-power entry blocks a wakeup
    lp_entry = 1; wake_en = '1; wake_req = '1;
    tick();
    drive_idle();
    check("R8 blocked evt", wake_evt, 0);
    check("R8 blocked status", irq_status, 0);
    // R6: escalation with all enables off
    prst_en = '0; prst_req = '1; esc = 1;
    tick();
    drive_idle();
    check("R6 esc only", rst_req, 5'b01000);
    check("R7 cause req", rst_cause, 2);
    lp_rst = 1;
    tick();
    drive_idle();
    check("R7 cause lp", rst_cause, 1);
    // random phase
    for (int c = 0; c < 3000; c++) begin
      wake_req   = NW'($urandom);
      wake_en    = NW'($urandom);
      capture_en = ($urandom % 4) != 0;
      wake_clr   = (($urandom % 5) == 0) ? NW'($urandom) : '0;
      lp_entry   = ($urandom % 4) == 0;
      irq_en     = $urandom % 2;
      irq_clr    = ($urandom % 5) == 0;
      prst_req   = NPR'($urandom);
      prst_en    = NPR'($urandom);
      glitch     = ($urandom % 8) == 0;
      esc        = ($urandom % 8) == 0;
      sw_rst     = ($urandom % 8) == 0;
      lp_rst     = ($urandom % 3) == 0;
      if (c == 1500) begin
        rst_n = 0;
        #1;
        check_reset_zero();
        tick();
        check_reset_zero();
        rst_n = 1;
      end
      tick();
    end
    comparing = 0;
  endtask

  initial begin
    drive_idle();
    fork
      run();
      begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule